// File: doc/BRIEF.md
# Entropy CRC Conditioner with Read Interlock

This block turns three single-bit raw noise inputs into a 64-bit random word. Each cycle the bits of the enabled inputs are folded into one bit by exclusive-or, and that bit is clocked into a 64-bit conditioning register. In CRC mode the register runs as a Galois CRC with a fixed 64-bit polynomial. In plain mode it acts as a simple left shift register. A small control register holds the source enables, the mode bit, a minimum-wait count and three analog-setting fields. The analog-setting fields are stored and read back but drive no logic.

A consumer reads the word through a request/ready pair. In CRC mode a counter throttles reads, so that every word carries enough freshly mixed entropy. After any accepted read, and after any control write, the ready signal stays low until the programmed number of cycles has gone by. In plain mode reads are never held off.

Top module: `entropy_crc_conditioner`

## Requirements
- R1: The mixed bit of a cycle is the XOR of `src_bits[k] & cfg[k]` for k = 0..2. When all three enables are clear the mixed bit is 0, whatever the inputs do.
- R2: With cfg bit 3 set (CRC mode), each clock computes f = word[63] XOR mixed bit. The next word is word shifted left by one, XORed with 64'h231DCEE91262B8A3 when f is 1.
- R3: With cfg bit 3 clear (plain mode), each clock shifts the word left by one, and the mixed bit enters bit 0.
- R4: The control register is 25 bits wide. A cycle with `cfg_wr` high loads `cfg_wdata` into it at the clock edge, and `cfg_rdata` returns all 25 bits. The layout is: bits 2:0 source enables, bit 3 mode, bits 5:4 analog select, bits 7:6 oscillator rate, bit 8 bypass, bits 24:9 minimum wait W. Bits 8:4 are stored and have no effect on the data or on ready.
- R5: After reset the word is 0 and the wait counter is 0. The control register holds a wait of 2048 with every other bit clear, which reads back as 25'h100000.
- R6: In CRC mode, `rd_ready` goes low in the cycle after an accepted read or a control write. It stays low for exactly W cycles and is high from the (W+1)th cycle on. With W = 0 it never drops.
- R7: In plain mode `rd_ready` is always high.
- R8: `rd_data` always shows the current conditioning word. A read is accepted in a cycle where `rd_req` and `rd_ready` are both high, and it returns the word of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_bits | input | 3 | Raw entropy bits, one per source |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 25 | Control register write value |
| cfg_rdata | output | 25 | Control register contents |
| rd_req | input | 1 | Read request |
| rd_ready | output | 1 | Interlock open; a read is accepted when both are high |
| rd_data | output | 64 | Current conditioned word |

## Verification
The main function is driven in three ways, and each one separates a different class of fault:
- Random source bits are applied under every enable combination in plain mode, which exposes errors in the gating and XOR mixing.
- The same random stream is applied in CRC mode with reads every cycle, which exposes a wrong polynomial or feedback tap.
- A single one-bit pulse is injected into a zero register, which must leave exactly the polynomial constant and so pins down the feedback tap positions directly.

The interlock is checked in two ways:
- A held request is used with short and default waits, which separates off-by-one errors in the count.
- A control write is made in the middle of a wait, which shows whether the counter restarts on a write.

// File: rtl/entropy_crc_conditioner.sv
module entropy_crc_conditioner #(
  parameter int WORD_W = 64,
  parameter logic [WORD_W-1:0] POLY = 64'h231DCEE91262B8A3,
  parameter int WAIT_W = 16,
  parameter int DEFAULT_WAIT = 2048
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    src_bits,
  input  logic                          cfg_wr,
  input  logic [9+WAIT_W-1:0]           cfg_wdata,
  output logic [9+WAIT_W-1:0]           cfg_rdata,
  input  logic                          rd_req,
  output logic                          rd_ready,
  output logic [WORD_W-1:0]             rd_data
);
  localparam int SRC_N    = 3;
  localparam int MODE_BIT = 3;
  localparam int WAIT_LSB = 9;
  localparam int CFG_W    = WAIT_LSB + WAIT_W;
  localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(DEFAULT_WAIT) << WAIT_LSB;

  logic [CFG_W-1:0]  cfg_q;
  logic [WORD_W-1:0] word_q, word_d;
  logic [WAIT_W-1:0] cnt_q;

  wire              crc_mode = cfg_q[MODE_BIT];
  wire [WAIT_W-1:0] min_wait = cfg_q[WAIT_LSB +: WAIT_W];
  wire              mix      = ^(src_bits & cfg_q[SRC_N-1:0]);
  wire              fb       = word_q[WORD_W-1] ^ mix;
  wire              accept   = rd_req && rd_ready;

  assign rd_ready  = !crc_mode || (cnt_q >= min_wait);
  assign rd_data   = word_q;
  assign cfg_rdata = cfg_q;

  always_comb begin
    if (crc_mode)
      word_d = {word_q[WORD_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    else
      word_d = {word_q[WORD_W-2:0], mix};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      if (cfg_wr)
        cfg_q <= cfg_wdata;
      if (accept || cfg_wr)
        cnt_q <= '0;
      else if (cnt_q != '1)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/entropy_crc_conditioner_chk.sv
module entropy_crc_conditioner_chk #(
  parameter int WORD_W = 64,
  parameter int WAIT_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          src_bits,
  input logic                cfg_wr,
  input logic [9+WAIT_W-1:0] cfg_wdata,
  input logic [9+WAIT_W-1:0] cfg_rdata,
  input logic                rd_req,
  input logic                rd_ready,
  input logic [WORD_W-1:0]   rd_data
);
  a_r7_plain_open: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[3] |-> rd_ready);

  a_r6_closes_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[3] && cfg_rdata[9 +: WAIT_W] != 0 && rd_req && rd_ready && !cfg_wr) |=> !rd_ready);

  a_r3_plain_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[3] |=> rd_data[WORD_W-1:1] == $past(rd_data[WORD_W-2:0]));

  a_r2_feedback_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[3] && (rd_data[WORD_W-1] ^ (^(src_bits & cfg_rdata[2:0])))) |=> rd_data[0]);

  a_r4_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_rdata == $past(cfg_wdata));

  a_r1_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[3] && cfg_rdata[2:0] == 3'b000) |=> !rd_data[0]);
endmodule

bind entropy_crc_conditioner entropy_crc_conditioner_chk #(.WORD_W(WORD_W), .WAIT_W(WAIT_W)) u_chk (.*);

// File: tb/tb_entropy_crc_conditioner.sv
module tb_entropy_crc_conditioner;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] POLY = 64'h231DCEE91262B8A3;
  localparam logic [24:0] CFG_RST = 25'h100000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  src_bits = 0;
  logic        cfg_wr = 0;
  logic [24:0] cfg_wdata = 0;
  logic [24:0] cfg_rdata;
  logic        rd_req = 0;
  logic        rd_ready;
  logic [63:0] rd_data;

  entropy_crc_conditioner dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  logic [63:0] expq[$];
  logic [63:0] m_word;
  logic [24:0] m_cfg;
  int          m_cnt;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic write_cfg(input logic [24:0] v);
    cfg_wr = 1; cfg_wdata = v;
    tick();
    cfg_wr = 0;
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      src_bits = 3'($urandom);
      tick();
    end
  endtask

  // reference model and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      m_word = 0; m_cfg = CFG_RST; m_cnt = 0;
    end else begin
      logic exp_ready, mix, fb, acc;
      exp_ready = !m_cfg[3] || (m_cnt >= int'(m_cfg[24:9]));
      acc = rd_req && exp_ready;
      if (rd_req) chk(rd_ready == exp_ready, m_cfg[3] ? "R6 ready" : "R7 ready",
                      64'(rd_ready), 64'(exp_ready));
      if (acc) expq.push_back(m_word);
      if (rd_req && rd_ready) begin
        if (expq.size() == 0) chk(0, "R8 unexpected accept", rd_data, 0);
        else begin
          logic [63:0] e;
          e = expq.pop_front();
          chk(rd_data == e, m_cfg[3] ? "R2/R8 crc word" : "R3/R8 plain word", rd_data, e);
        end
      end
      mix = ^(src_bits & m_cfg[2:0]);
      if (m_cfg[3]) begin
        fb = m_word[63] ^ mix;
        m_word = {m_word[62:0], 1'b0} ^ (fb ? POLY : 64'h0);
      end else
        m_word = {m_word[62:0], mix};
      if (acc || cfg_wr) m_cnt = 0;
      else if (m_cnt < 65535) m_cnt++;
      if (cfg_wr) m_cfg = cfg_wdata;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int n;
    tick(3);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_rdata == CFG_RST, "R5 cfg reset", 64'(cfg_rdata), 64'(CFG_RST));
    chk(rd_data == 0, "R5 word reset", rd_data, 0);
    chk(rd_ready == 1, "R7 ready in plain mode after reset", 64'(rd_ready), 1);

    // R3/R7 plain mode with each enable combination, reads every cycle
    rd_req = 1;
    for (int en = 1; en < 8; en++) begin
      write_cfg(25'(en));
      rand_run(40);
    end
    rd_req = 0;

    // R1 disabled sources leave zeros
    write_cfg(25'h0);
    rand_run(70);
    @(negedge clk);
    chk(rd_data == 0, "R1 disabled sources", rd_data, 0);

    // R2 single pulse into zero register gives polynomial constant
    src_bits = 0;
    write_cfg(25'h9);
    src_bits = 3'b001;
    tick();
    src_bits = 3'b000;
    @(negedge clk);
    chk(rd_data == POLY, "R2 one-bit pulse", rd_data, POLY);

    // R2 crc mode, wait 0, random stream, read every cycle
    rd_req = 1;
    write_cfg(25'hF);
    rand_run(200);
    write_cfg(25'hA);
    rand_run(100);
    rd_req = 0;

    // R4 unused fields stored
    write_cfg(25'h1F1F0 | 25'h1F0);
    @(negedge clk);
    chk(cfg_rdata == (25'h1F1F0 | 25'h1F0), "R4 readback", 64'(cfg_rdata), 64'(25'h1F1F0 | 25'h1F0));

    // R6 wait of 5 cycles after control write
    write_cfg((25'd5 << 9) | 25'hF);
    for (int i = 0; i <= 5; i++) begin
      @(negedge clk);
      chk(rd_ready == (i >= 5), "R6 wait count after write", 64'(rd_ready), 64'(i >= 5));
    end
    // held request: model checks spacing
    rd_req = 1;
    rand_run(60);
    // control write mid-wait restarts the count
    write_cfg((25'd7 << 9) | 25'hF);
    tick(3);
    write_cfg((25'd7 << 9) | 25'hF);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      chk(rd_ready == 0, "R6 restart on write", 64'(rd_ready), 0);
    end
    rand_run(40);
    rd_req = 0;

    // R6 default wait of 2048
    write_cfg(CFG_RST | 25'hF);
    n = 0;
    @(negedge clk);
    while (!rd_ready && n < 5000) begin
      n++;
      @(negedge clk);
    end
    chk(n == 2048, "R5/R6 default wait", 64'(n), 2048);
    rd_req = 1;
    tick(2);
    rd_req = 0;
    tick(2);
    chk(expq.size() == 0, "R8 scoreboard drained", 64'(expq.size()), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule